// File: doc/BRIEF.md
# Three-State Snooping Line Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache. It sits between one processor port and a shared snooping bus. Processor reads and writes are looked up in a tag and state array. A hit finishes in the cycle it is presented. A miss, or a write to a clean copy, raises a bus request and holds it until a one-cycle grant arrives. On that grant the new tag and state are written.

Transactions that other agents place on the bus are presented on a snoop port. The controller downgrades or invalidates its own copy of the addressed line. When it holds the only dirty copy, it pulses a write-back strobe. Replacing a dirty line on a refill pulses the same strobe with the victim's address. Data storage, arbitration and memory are outside the block, and the write-back strobe is only a handshake pulse.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `line_state`, `bus_req` is idle and `cpu_ready` is high. The states are encoded Invalid=00, Shared=01, Modified=10. `line_state` always shows the state of the line addressed by `cpu_addr`, or 00 when the tag differs.
- R2: An accepted read to a Shared or Modified line asserts `cpu_hit` and `cpu_done` in the same cycle. It raises no bus request and leaves the state unchanged.
- R3: An accepted write to a Modified line is a hit: `cpu_hit` and `cpu_done` are high in that cycle and the line stays Modified.
- R4: A read miss drives `bus_req`=01 (bus read) from the next cycle. The request holds until `bus_gnt`, after which the line is Shared with the new tag. Other codes: 00 idle, 10 read-exclusive, 11 upgrade.
- R5: A write to an absent or Invalid line requests read-exclusive (10) and becomes Modified on grant.
- R6: A write to a Shared line requests upgrade (11) and becomes Modified on grant.
- R7: A snooped bus read to a Modified line pulses `wb_flush` in the same cycle with `wb_addr`=`snp_addr` and leaves the line Shared. Snoop codes: 000 none, 001 read, 010 read-exclusive, 011 upgrade, 100 write-back.
- R8: A snooped read-exclusive or upgrade to a Modified line pulses `wb_flush` and invalidates the line.
- R9: A snooped read-exclusive or upgrade to a Shared line invalidates it without a flush. A snooped read leaves a Shared line Shared. A snooped write-back, or any snoop to a line not held, has no effect.
- R10: A grant that refills an index whose resident line is Modified with a different tag pulses `wb_flush` with the victim's address.
- R11: While a request is pending, or while a snoop code 001..100 is present, `cpu_ready` is low and processor requests are ignored. A grant with nothing pending is ignored.
- R12: If a pending upgrade loses its Shared copy to a snoop, the request becomes read-exclusive (10) from the next cycle.
- R13: A snoop presented in the same cycle as the grant of the block's own pending request is ignored.
- R14: `cpu_done` pulses in the grant cycle, and `bus_req` returns to 00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request (wins over read) |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Processor request may be accepted this cycle |
| cpu_hit | output | 1 | Accepted request hit without a bus transaction |
| cpu_done | output | 1 | Processor request completed this cycle |
| line_state | output | 2 | State of the line addressed by cpu_addr |
| bus_req | output | 2 | Pending bus request kind |
| bus_addr | output | ADDR_W | Address of the pending bus request |
| bus_gnt | input | 1 | One-cycle grant of the pending request |
| snp_op | input | 3 | Snooped transaction kind |
| snp_addr | input | ADDR_W | Snooped line address |
| wb_flush | output | 1 | Write-back strobe for a dirty line |
| wb_addr | output | ADDR_W | Address of the line being written back |

## Verification
The checker watches every cycle for the following:
- the processor is locked out while a request is pending;
- a pending request holds steady until its grant, except when an upgrade is converted;
- the request clears after a grant;
- a killed upgrade reappears as read-exclusive;
- the write-back strobe never fires without a snoop or a grant;
- no snoop flush happens in a grant cycle.

Only the bench's scenarios can show the state each line ends in. These cover refills into Shared or Modified, downgrades and invalidations by snoops, victim write-back on a refill, and snoops with no effect. The bench compares them against a model of the array driven by random and directed traffic.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_M = 2'b10
  } line_st_t;

  typedef enum logic [1:0] {
    BQ_NONE = 2'b00,
    BQ_RD   = 2'b01,
    BQ_RDX  = 2'b10,
    BQ_UPG  = 2'b11
  } bus_req_t;

  localparam logic [2:0] SN_NONE  = 3'd0;
  localparam logic [2:0] SN_RD    = 3'd1;
  localparam logic [2:0] SN_RDX   = 3'd2;
  localparam logic [2:0] SN_UPG   = 3'd3;
  localparam logic [2:0] SN_FLUSH = 3'd4;

  function automatic logic f_snoop_present(input logic [2:0] op);
    return (op == SN_RD) || (op == SN_RDX) || (op == SN_UPG) || (op == SN_FLUSH);
  endfunction

  // A processor access hits when no bus transaction is needed.
  function automatic logic f_cpu_hit(input logic is_wr, input line_st_t st);
    return is_wr ? (st == ST_M) : (st != ST_I);
  endfunction

  function automatic bus_req_t f_cpu_bus(input logic is_wr, input line_st_t st);
    if (!is_wr) return BQ_RD;
    return (st == ST_S) ? BQ_UPG : BQ_RDX;
  endfunction

  function automatic line_st_t f_commit_state(input bus_req_t kind);
    return (kind == BQ_RD) ? ST_S : ST_M;
  endfunction

  function automatic line_st_t f_snoop_next(input logic [2:0] op, input line_st_t st);
    case (op)
      SN_RD:          return (st == ST_M) ? ST_S : st;
      SN_RDX, SN_UPG: return ST_I;
      default:        return st;
    endcase
  endfunction

  function automatic logic f_snoop_flush(input logic [2:0] op, input line_st_t st);
    return (st == ST_M) && ((op == SN_RD) || (op == SN_RDX) || (op == SN_UPG));
  endfunction

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_t         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_t         b_st,
  input  logic [IDX_W-1:0] c_idx,
  output logic [TAG_W-1:0] c_tag,
  output line_st_t         c_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st
);

  logic [TAG_W-1:0] tag_arr [LINES];
  line_st_t         st_arr  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] t_q;
    line_st_t         s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        s_q <= ST_I;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        t_q <= wr_tag;
        s_q <= wr_st;
      end
    end
    assign tag_arr[g] = t_q;
    assign st_arr[g]  = s_q;
  end

  assign a_tag = tag_arr[a_idx];
  assign a_st  = st_arr[a_idx];
  assign b_tag = tag_arr[b_idx];
  assign b_st  = st_arr[b_idx];
  assign c_tag = tag_arr[c_idx];
  assign c_st  = st_arr[c_idx];

endmodule

// File: rtl/msi_req_track.sv
module msi_req_track
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bus_req_t          start_kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              commit,
  input  logic              kill,
  output logic              pend,
  output bus_req_t          kind_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      kind_q <= BQ_NONE;
      addr_q <= '0;
    end else if (commit) begin
      pend   <= 1'b0;
      kind_q <= BQ_NONE;
    end else if (start) begin
      pend   <= 1'b1;
      kind_q <= start_kind;
      addr_q <= start_addr;
    end else if (kill) begin
      kind_q <= BQ_RDX;
    end
  end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic              cpu_done,
  output logic [1:0]        line_state,
  output logic [1:0]        bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic [2:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              wb_flush,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic line_st_t f_eff(input logic [TAG_W-1:0] stored,
                                     input line_st_t st,
                                     input logic [ADDR_W-1:0] a);
    return (stored == f_tag(a)) ? st : ST_I;
  endfunction

  logic [TAG_W-1:0] a_tag, b_tag, c_tag;
  line_st_t         a_raw, b_raw, c_st;
  line_st_t         a_st, b_st;
  logic             pend;
  bus_req_t         kind_q;
  logic [ADDR_W-1:0] addr_q;

  // named internal events
  logic     snp_valid, snp_act, snp_flush, snp_kill;
  line_st_t snp_nxt;
  logic     commit, evict_flush;
  logic     cpu_acc, cpu_is_wr, hit_now, start;
  bus_req_t start_kind;
  logic     arr_we;
  logic [IDX_W-1:0] arr_idx;
  logic [TAG_W-1:0] arr_tag;
  line_st_t arr_st;

  msi_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (f_idx(cpu_addr)),
    .a_tag  (a_tag),
    .a_st   (a_raw),
    .b_idx  (f_idx(snp_addr)),
    .b_tag  (b_tag),
    .b_st   (b_raw),
    .c_idx  (f_idx(addr_q)),
    .c_tag  (c_tag),
    .c_st   (c_st),
    .wr_en  (arr_we),
    .wr_idx (arr_idx),
    .wr_tag (arr_tag),
    .wr_st  (arr_st)
  );

  msi_req_track #(.ADDR_W(ADDR_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (start_kind),
    .start_addr (cpu_addr),
    .commit     (commit),
    .kill       (snp_kill),
    .pend       (pend),
    .kind_q     (kind_q),
    .addr_q     (addr_q)
  );

  assign a_st = f_eff(a_tag, a_raw, cpu_addr);
  assign b_st = f_eff(b_tag, b_raw, snp_addr);

  // bus side
  assign commit      = pend && bus_gnt;
  assign snp_valid   = f_snoop_present(snp_op) && !commit;
  assign snp_act     = snp_valid && (b_st != ST_I);
  assign snp_nxt     = f_snoop_next(snp_op, b_st);
  assign snp_flush   = snp_act && f_snoop_flush(snp_op, b_st);
  assign snp_kill    = snp_act && pend && (kind_q == BQ_UPG) &&
                       (snp_addr == addr_q) && (snp_nxt == ST_I);
  assign evict_flush = commit && (c_st == ST_M) && (c_tag != f_tag(addr_q));

  // processor side
  assign cpu_ready  = !pend && !f_snoop_present(snp_op);
  assign cpu_acc    = cpu_ready && (cpu_rd || cpu_wr);
  assign cpu_is_wr  = cpu_wr;
  assign hit_now    = cpu_acc && f_cpu_hit(cpu_is_wr, a_st);
  assign start      = cpu_acc && !hit_now;
  assign start_kind = f_cpu_bus(cpu_is_wr, a_st);

  // array write port: snoop update or refill commit (never both)
  always_comb begin
    arr_we  = 1'b0;
    arr_idx = f_idx(addr_q);
    arr_tag = f_tag(addr_q);
    arr_st  = f_commit_state(kind_q);
    if (snp_act) begin
      arr_we  = 1'b1;
      arr_idx = f_idx(snp_addr);
      arr_tag = f_tag(snp_addr);
      arr_st  = snp_nxt;
    end else if (commit) begin
      arr_we  = 1'b1;
    end
  end

  assign cpu_hit    = hit_now;
  assign cpu_done   = hit_now || commit;
  assign line_state = a_st;
  assign bus_req    = kind_q;
  assign bus_addr   = addr_q;
  assign wb_flush   = snp_flush || evict_flush;
  assign wb_addr    = snp_flush ? snp_addr : {c_tag, f_idx(addr_q)};

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       cpu_hit,
  input logic       cpu_done,
  input logic [1:0] bus_req,
  input logic       bus_gnt,
  input logic [2:0] snp_op,
  input logic       wb_flush,
  input logic       pend,
  input logic       snp_kill,
  input logic       snp_flush
);

  // R11
  pend_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req != 2'b00) |-> !cpu_ready);

  // R2
  hit_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_done && bus_req == 2'b00));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req != 2'b00 && !bus_gnt && !snp_kill) |=> (bus_req == $past(bus_req)));

  // R14
  grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bus_gnt) |=> (bus_req == 2'b00));

  // R12
  upg_to_rdx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> (bus_req == 2'b10));

  // R10
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_flush |-> (snp_op != 3'd0 || (pend && bus_gnt)));

  // R13
  grant_snoop_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bus_gnt) |-> !snp_flush);

  // R1
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (bus_req == 2'b00));

endmodule

bind msi_line_ctrl msi_line_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .cpu_hit   (cpu_hit),
  .cpu_done  (cpu_done),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .snp_op    (snp_op),
  .wb_flush  (wb_flush),
  .pend      (pend),
  .snp_kill  (snp_kill),
  .snp_flush (snp_flush)
);

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic       cpu_ready, cpu_hit, cpu_done;
  logic [1:0] line_state, bus_req;
  logic [7:0] bus_addr;
  logic       bus_gnt = 1'b0;
  logic [2:0] snp_op = '0;
  logic [7:0] snp_addr = '0;
  logic       wb_flush;
  logic [7:0] wb_addr;

  always #4 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(8), .LINES(4)) i_msi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_done(cpu_done),
    .line_state(line_state), .bus_req(bus_req), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snp_op(snp_op), .snp_addr(snp_addr), .wb_flush(wb_flush), .wb_addr(wb_addr)
  );

  localparam logic [1:0] I = 2'b00, S = 2'b01, M = 2'b10;
  localparam logic [1:0] Q_RD = 2'b01, Q_RDX = 2'b10, Q_UPG = 2'b11;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [5:0] m_tag [4];
  logic [1:0] m_st  [4];
  logic       m_pend;
  logic [1:0] m_kind;
  logic [7:0] m_addr;

  // last observations
  logic o_ready, o_hit, o_done, o_flush;
  logic [1:0] o_ls, o_br;
  logic [7:0] o_faddr;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [1:0] look(input logic [7:0] a);
    if (m_tag[a[1:0]] == a[7:2]) return m_st[a[1:0]];
    return I;
  endfunction

  task automatic cyc(input logic rd, input logic wr, input logic [7:0] a,
                     input logic [2:0] sop, input logic [7:0] sa, input logic g);
    logic sp, sv, rdy, acc, hit, com, sfl, efl, xfl;
    logic [1:0] ast, bst, nst, vi;
    logic [7:0] xfa;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; snp_op = sop; snp_addr = sa; bus_gnt = g;
    #1;
    sp  = (sop >= 3'd1 && sop <= 3'd4);
    com = m_pend && g;
    sv  = sp && !com;
    rdy = !m_pend && !sp;
    acc = rdy && (rd || wr);
    ast = look(a);
    hit = acc && (wr ? (ast == M) : (ast != I));
    bst = look(sa);
    sfl = sv && (bst == M) && (sop != 3'd4);
    vi  = m_addr[1:0];
    efl = com && (m_st[vi] == M) && (m_tag[vi] != m_addr[7:2]);
    xfl = sfl || efl;
    xfa = sfl ? sa : {m_tag[vi], vi};
    o_ready = cpu_ready; o_hit = cpu_hit; o_done = cpu_done; o_flush = wb_flush;
    o_ls = line_state; o_br = bus_req; o_faddr = wb_addr;
    chk("R11 cpu_ready", cpu_ready, rdy);
    chk("R2 cpu_hit", cpu_hit, hit);
    chk("R14 cpu_done", cpu_done, hit || com);
    chk("R4 bus_req", bus_req, m_pend ? m_kind : 2'b00);
    chk("R1 line_state", line_state, ast);
    chk("R7 wb_flush", wb_flush, xfl);
    if (xfl) chk("R10 wb_addr", wb_addr, xfa);
    if (m_pend) chk("R4 bus_addr", bus_addr, m_addr);
    @(posedge clk);
    if (sv && bst != I) begin
      case (sop)
        3'd1: nst = (bst == M) ? S : bst;
        3'd2, 3'd3: nst = I;
        default: nst = bst;
      endcase
      m_st[sa[1:0]] = nst;
      if (m_pend && m_kind == Q_UPG && sa == m_addr && nst == I) m_kind = Q_RDX;
    end else if (com) begin
      m_tag[vi] = m_addr[7:2];
      m_st[vi]  = (m_kind == Q_RD) ? S : M;
      m_pend = 0;
      m_kind = 2'b00;
    end
    if (acc && !hit) begin
      m_pend = 1;
      m_kind = wr ? ((ast == S) ? Q_UPG : Q_RDX) : Q_RD;
      m_addr = a;
    end
  endtask

  task automatic idle(input logic [7:0] a);
    cyc(0, 0, a, 3'd0, 8'h00, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [7:0] A = 8'h04, B = 8'h08, C = 8'h05, C2 = 8'h09;

  initial begin
    for (int k = 0; k < 4; k++) begin m_tag[k] = '0; m_st[k] = I; end
    m_pend = 0; m_kind = 2'b00; m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      idle(8'(k * 3));
      chk("R1 reset line_state", o_ls, I);
      chk("R1 reset ready", o_ready, 1);
      chk("R1 reset bus_req", o_br, 2'b00);
    end
    // R4 read miss
    cyc(1, 0, A, 0, 0, 0);
    idle(A); chk("R4 read req code", o_br, Q_RD);
    cyc(0, 0, A, 0, 0, 1); chk("R14 done on grant", o_done, 1);
    idle(A); chk("R4 line shared", o_ls, S); chk("R14 req cleared", o_br, 2'b00);
    // R2 read hit
    cyc(1, 0, A, 0, 0, 0); chk("R2 read hit", o_hit, 1);
    // R6 upgrade
    cyc(0, 1, A, 0, 0, 0);
    idle(A); chk("R6 upgrade code", o_br, Q_UPG);
    cyc(0, 0, A, 0, 0, 1);
    idle(A); chk("R6 line modified", o_ls, M);
    // R3 write hit
    cyc(0, 1, A, 0, 0, 0); chk("R3 write hit", o_hit, 1);
    idle(A); chk("R3 stays modified", o_ls, M);
    // R7 snoop read on M
    cyc(0, 0, A, 3'd1, A, 0); chk("R7 flush", o_flush, 1); chk("R7 flush addr", o_faddr, A);
    idle(A); chk("R7 downgraded", o_ls, S);
    // R9 snoop rdx on S
    cyc(0, 0, A, 3'd2, A, 0); chk("R9 no flush", o_flush, 0);
    idle(A); chk("R9 invalidated", o_ls, I);
    // R5 write miss
    cyc(0, 1, C, 0, 0, 0);
    idle(C); chk("R5 rdx code", o_br, Q_RDX);
    cyc(0, 0, C, 0, 0, 1);
    idle(C); chk("R5 line modified", o_ls, M);
    // R9 snoop write-back / absent line: no effect
    cyc(0, 0, C, 3'd4, C, 0); chk("R9 wb snoop no flush", o_flush, 0);
    cyc(0, 0, C, 3'd2, C2, 0); chk("R9 absent snoop no flush", o_flush, 0);
    idle(C); chk("R9 unchanged", o_ls, M);
    // R8 snoop upgrade on M
    cyc(0, 0, C, 3'd3, C, 0); chk("R8 flush", o_flush, 1);
    idle(C); chk("R8 invalidated", o_ls, I);
    // R10 eviction of dirty victim
    cyc(0, 1, C, 0, 0, 0); cyc(0, 0, C, 0, 0, 1);
    cyc(1, 0, C2, 0, 0, 0);
    cyc(0, 0, C2, 0, 0, 1); chk("R10 evict flush", o_flush, 1); chk("R10 evict addr", o_faddr, C);
    // R12 upgrade killed by snoop
    cyc(1, 0, A, 0, 0, 0); cyc(0, 0, A, 0, 0, 1);
    cyc(0, 1, A, 0, 0, 0);
    cyc(0, 0, A, 3'd2, A, 0);
    idle(A); chk("R12 converted to rdx", o_br, Q_RDX);
    cyc(0, 0, A, 0, 0, 1);
    idle(A); chk("R12 line modified", o_ls, M);
    // R13 snoop in grant cycle ignored
    cyc(1, 0, B, 0, 0, 0);
    cyc(0, 0, B, 3'd2, C2, 1); chk("R13 evict flush only", o_faddr, A);
    idle(C2); chk("R13 snoop ignored", o_ls, S);
    // R11 lockout and stray grant
    cyc(0, 1, C2, 0, 0, 0);
    cyc(1, 0, A, 0, 0, 0); chk("R11 locked while pending", o_ready, 0);
    cyc(0, 0, C2, 0, 0, 1);
    cyc(0, 1, B, 3'd1, C, 0); chk("R11 locked by snoop", o_ready, 0);
    idle(B); chk("R11 write ignored", o_br, 2'b00); chk("R11 B still shared", o_ls, S);
    cyc(0, 0, B, 0, 0, 1); idle(B); chk("R11 stray grant", o_br, 2'b00);

    // constrained random traffic
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ra, sa;
      logic [2:0] so;
      logic rr, rw;
      ra = {4'd0, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
      sa = {4'd0, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
      so = ($urandom_range(0, 99) < 25) ? 3'($urandom_range(1, 4)) : 3'd0;
      rr = $urandom_range(0, 1);
      rw = ($urandom_range(0, 2) == 0);
      cyc(rr, rw, ra, so, sa, ($urandom_range(0, 99) < 35));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule